// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It watches the byte stream of an incoming frame, collects the destination address (the first six bytes), and decides whether the frame is wanted. There are three ways to classify the address. An all-ones address is a broadcast. An address with the group bit set, or any address while the all-hash mode is on, goes through a 64-entry hash table indexed by CRC-32 bits. Any other address must equal the station address exactly.

The decision comes out as a single-cycle pulse on the cycle after the sixth address byte is taken. If the frame ends before six bytes arrive, the pulse comes on the cycle after its last byte. Along with the pulse the block gives an accept bit, which tells the storage logic to keep the frame. It also gives a miss bit, which is written into the receive descriptor, and a class code. In promiscuous mode every frame is accepted, but a frame that failed the filter still carries the miss bit.

Top module: `da_filter`

## Requirements
- R1: A decision pulse (`dec_valid` high for one cycle) appears on the cycle after the clock edge that takes the sixth byte of a frame. Bytes after the sixth produce no further pulse.
- R2: A frame whose last byte (`in_last`) comes before six bytes have arrived is decided on the cycle after that byte. It is a miss with class code 0.
- R3: A destination of all ones has class code 1 and is a miss exactly when `cfg_bc_reject` is 1. Broadcast takes precedence over the hash path.
- R4: A non-broadcast destination whose first byte has bit 0 set, or any non-broadcast destination while `cfg_hash_all` is 1, has class code 2. It is looked up in the hash table. The index is bits 31:26 of the complemented CRC-32 of the six address bytes. The CRC uses the reflected polynomial 0xEDB88320, starts at all ones, and takes each byte least-significant bit first.
- R5: Hash index values 0..31 select that bit of `cfg_hash0`, and values 32..63 select bit (index-32) of `cfg_hash1`. A selected bit of 1 is a hit, and 0 is a miss.
- R6: Any other destination has class code 3 and hits only if it matches the station address byte for byte. Address byte 0 is compared with `cfg_sta_hi[15:8]` and byte 1 with `cfg_sta_hi[7:0]`. Bytes 2..5 are compared with `cfg_sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order.
- R7: With `cfg_promisc` at 0, `dec_accept` is the inverse of `dec_miss`. With `cfg_promisc` at 1, `dec_accept` is 1 and `dec_miss` still reports the filter result.
- R8: A byte marked `in_first` always starts a new capture, even if an earlier frame is unfinished. A byte without `in_first` that arrives while no frame is open is ignored and produces no decision.
- R9: While and after reset, and until a frame is decided, `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A receive byte is present this cycle |
| in_first | input | 1 | The byte is the first of a frame |
| in_last | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Receive byte |
| cfg_sta_hi | input | 16 | Station address bytes 0 and 1 |
| cfg_sta_lo | input | 32 | Station address bytes 2 to 5 |
| cfg_hash0 | input | 32 | Hash table entries 0 to 31 |
| cfg_hash1 | input | 32 | Hash table entries 32 to 63 |
| cfg_bc_reject | input | 1 | Treat broadcast as a miss |
| cfg_hash_all | input | 1 | Send every non-broadcast address through the hash table |
| cfg_promisc | input | 1 | Accept frames that miss the filter |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Keep the frame |
| dec_miss | output | 1 | Filter miss, for the descriptor |
| dec_class | output | 2 | Class code: 0 short, 1 broadcast, 2 hash, 3 exact |

## Verification
The assertions check on every cycle the rules that can be read from the ports:
- the accept/miss relation in both promiscuous settings;
- that broadcast and short decisions carry the right miss value;
- that a decision only follows an accepted byte;
- that the sixth byte always yields a full-length decision;
- that stray bytes never do.

Only the bench scenarios can show that the hash index comes from the right CRC bits and picks the right table word, and that each station address byte is compared at its own field position. They also show that a restart mid-frame discards the old bytes. The bench covers these by sweeping many multicast and forced-hash addresses against computed CRCs, and by flipping each address byte in turn.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int CRC_W      = 32;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_REG_W = 32;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;

    typedef enum logic [1:0] {
        CLS_SHORT = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_HASH  = 2'd2,
        CLS_EXACT = 2'd3
    } da_class_e;

    typedef struct packed {
        logic      accept;
        logic      miss;
        da_class_e cls;
    } da_verdict_t;

    // One byte of a reflected CRC, least-significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            if (c[0] ^ data[b]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic hash_lookup(
        input logic [HASH_IDX_W-1:0] idx,
        input logic [HASH_REG_W-1:0] tbl0,
        input logic [HASH_REG_W-1:0] tbl1
    );
        logic [HASH_IDX_W-2:0] bitsel;
        bitsel = idx[HASH_IDX_W-2:0];
        return idx[HASH_IDX_W-1] ? tbl1[bitsel] : tbl0[bitsel];
    endfunction

endpackage

// File: rtl/dafilt_capture.sv
module dafilt_capture
    import dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [BYTE_W-1:0] in_data,
    output logic              store_en,
    output logic              store_first,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              short_frame
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] slot;
    logic [CNT_W-1:0] next_cnt;
    logic             open;
    logic             store_more;

    assign store_first = in_valid && in_first;
    assign store_more  = in_valid && !in_first && open;
    assign store_en    = store_first || store_more;
    assign slot        = store_first ? '0 : cnt;
    assign next_cnt    = slot + CNT_W'(1);

    // One register per address byte; byte 0 lands in the top bits.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)                                  lane_q <= '0;
            else if (store_en && slot == CNT_W'(g))   lane_q <= in_data;
        end
        assign addr[ADDR_W-1-g*BYTE_W -: BYTE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            open        <= 1'b0;
            done        <= 1'b0;
            short_frame <= 1'b0;
        end else begin
            done        <= 1'b0;
            short_frame <= 1'b0;
            if (store_en) begin
                cnt <= next_cnt;
                if (next_cnt == CNT_W'(ADDR_BYTES)) begin
                    done <= 1'b1;
                    open <= 1'b0;
                end else if (in_last) begin
                    done        <= 1'b1;
                    short_frame <= 1'b1;
                    open        <= 1'b0;
                end else begin
                    open <= 1'b1;
                end
            end
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(ADDR_BYTES));

    assert_sixth_byte_R1: assert property (@(posedge clk) disable iff (rst)
        (store_more && cnt == CNT_W'(ADDR_BYTES - 1)) |=> (done && !short_frame));

    assert_stray_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_first && !open) |=> !done);

endmodule

// File: rtl/dafilt_crc.sv
module dafilt_crc
    import dafilt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  restart,
    input  logic [BYTE_W-1:0]     data,
    output logic [HASH_IDX_W-1:0] hash_idx
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    assign crc_base = restart ? '1 : crc_q;

    always_ff @(posedge clk) begin
        if (rst)     crc_q <= '1;
        else if (en) crc_q <= crc_step_byte(crc_base, data);
    end

    // Final complement, then the top bits form the table index.
    assign hash_idx = ~crc_q[CRC_W-1 -: HASH_IDX_W];

endmodule

// File: rtl/dafilt_classify.sv
module dafilt_classify
    import dafilt_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic                  short_frame,
    input  logic [15:0]           sta_hi,
    input  logic [31:0]           sta_lo,
    input  logic [HASH_REG_W-1:0] hash0,
    input  logic [HASH_REG_W-1:0] hash1,
    input  logic                  bc_reject,
    input  logic                  hash_all,
    input  logic                  promisc,
    output da_verdict_t           verdict
);
    logic is_bcast;
    logic is_group;
    logic hash_hit;
    logic exact_hit;
    logic miss;

    assign is_bcast  = &addr;
    assign is_group  = addr[ADDR_W - BYTE_W];
    assign hash_hit  = hash_lookup(hash_idx, hash0, hash1);
    assign exact_hit = (addr == {sta_hi, sta_lo});

    always_comb begin
        if (short_frame) begin
            verdict.cls = CLS_SHORT;
            miss        = 1'b1;
        end else if (is_bcast) begin
            verdict.cls = CLS_BCAST;
            miss        = bc_reject;
        end else if (is_group || hash_all) begin
            verdict.cls = CLS_HASH;
            miss        = !hash_hit;
        end else begin
            verdict.cls = CLS_EXACT;
            miss        = !exact_hit;
        end
        verdict.miss   = miss;
        verdict.accept = !miss || promisc;
    end

endmodule

// File: rtl/da_filter.sv
module da_filter
    import dafilt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_first,
    input  logic        in_last,
    input  logic [7:0]  in_data,
    input  logic [15:0] cfg_sta_hi,
    input  logic [31:0] cfg_sta_lo,
    input  logic [31:0] cfg_hash0,
    input  logic [31:0] cfg_hash1,
    input  logic        cfg_bc_reject,
    input  logic        cfg_hash_all,
    input  logic        cfg_promisc,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic        dec_miss,
    output logic [1:0]  dec_class
);
    logic                  store_en;
    logic                  store_first;
    logic [ADDR_W-1:0]     addr;
    logic                  done;
    logic                  short_frame;
    logic [HASH_IDX_W-1:0] hash_idx;
    da_verdict_t           verdict;

    dafilt_capture u_capture (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_first    (in_first),
        .in_last     (in_last),
        .in_data     (in_data),
        .store_en    (store_en),
        .store_first (store_first),
        .addr        (addr),
        .done        (done),
        .short_frame (short_frame)
    );

    dafilt_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .en       (store_en),
        .restart  (store_first),
        .data     (in_data),
        .hash_idx (hash_idx)
    );

    dafilt_classify u_classify (
        .addr        (addr),
        .hash_idx    (hash_idx),
        .short_frame (short_frame),
        .sta_hi      (cfg_sta_hi),
        .sta_lo      (cfg_sta_lo),
        .hash0       (cfg_hash0),
        .hash1       (cfg_hash1),
        .bc_reject   (cfg_bc_reject),
        .hash_all    (cfg_hash_all),
        .promisc     (cfg_promisc),
        .verdict     (verdict)
    );

    assign dec_valid  = done;
    assign dec_accept = verdict.accept;
    assign dec_miss   = verdict.miss;
    assign dec_class  = verdict.cls;

    assert_valid_follows_byte_R1: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(in_valid));

    assert_short_is_miss_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_class == CLS_SHORT) |-> dec_miss);

    assert_bcast_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_class == CLS_BCAST) |-> (dec_miss == cfg_bc_reject));

    assert_drop_on_miss_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !cfg_promisc) |-> (dec_accept != dec_miss));

    assert_promisc_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && cfg_promisc) |-> dec_accept);

endmodule

// File: tb/sim_da_filter.sv
module sim_da_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [15:0] sta_hi = 16'h021A;
    logic [31:0] sta_lo = 32'h2B3C_4D5E;
    logic [31:0] h0 = 32'h0;
    logic [31:0] h1 = 32'h0;
    logic        bc_rej = 1'b0;
    logic        hall = 1'b0;
    logic        prom = 1'b0;
    logic        dec_valid, dec_accept, dec_miss;
    logic [1:0]  dec_class;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    da_filter u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last), .in_data(in_data),
        .cfg_sta_hi(sta_hi), .cfg_sta_lo(sta_lo), .cfg_hash0(h0), .cfg_hash1(h1),
        .cfg_bc_reject(bc_rej), .cfg_hash_all(hall), .cfg_promisc(prom),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss),
        .dec_class(dec_class)
    );

    function automatic logic [5:0] ref_index(input logic [47:0] da);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ da[47 - 8*i - 7 + b];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        c = ~c;
        return c[31:26];
    endfunction

    function automatic logic [47:0] next_addr();
        seed = seed * 32'd1103515245 + 32'd12345;
        next_addr[47:24] = seed[31:8];
        seed = seed * 32'd1103515245 + 32'd12345;
        next_addr[23:0] = seed[31:8];
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_decision(input logic [47:0] da, input int total, input string tag);
        logic [1:0] ecls;
        logic       emiss;
        logic [5:0] idx;
        logic       hit;
        if (total < 6) begin
            ecls = 2'd0; emiss = 1'b1;
        end else if (da == 48'hFFFF_FFFF_FFFF) begin
            ecls = 2'd1; emiss = bc_rej;
        end else if (da[40] || hall) begin
            idx  = ref_index(da);
            hit  = (idx >= 6'd32) ? h1[idx - 6'd32] : h0[idx];
            ecls = 2'd2; emiss = !hit;
        end else begin
            ecls = 2'd3;
            emiss = (da[47:40] != sta_hi[15:8]) || (da[39:32] != sta_hi[7:0]) ||
                    (da[31:24] != sta_lo[31:24]) || (da[23:16] != sta_lo[23:16]) ||
                    (da[15:8] != sta_lo[15:8]) || (da[7:0] != sta_lo[7:0]);
        end
        chk(dec_valid === 1'b1, "R1 decision pulse", 48'(dec_valid), 48'd1);
        chk(dec_class === ecls, tag, 48'(dec_class), 48'(ecls));
        chk(dec_miss === emiss, tag, 48'(dec_miss), 48'(emiss));
        chk(dec_accept === (!emiss || prom), "R7 accept", 48'(dec_accept), 48'(!emiss || prom));
    endtask

    task automatic observe(input int j, input int total, input logic [47:0] da,
                           input string tag);
        if (j == 5 || (j == total - 1 && total < 6)) expect_decision(da, total, tag);
        else chk(dec_valid === 1'b0, "R1 no extra pulse", 48'(dec_valid), 48'd0);
    endtask

    task automatic send(input logic [47:0] da, input int total, input string tag);
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            if (i > 0) observe(i - 1, total, da, tag);
            in_valid = 1'b1;
            in_first = (i == 0);
            in_last  = (i == total - 1);
            in_data  = (i < 6) ? da[47 - 8*i -: 8] : (8'hC3 ^ 8'(i));
        end
        @(negedge clk);
        observe(total - 1, total, da, tag);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        @(negedge clk);
        chk(dec_valid === 1'b0, "R1 single pulse", 48'(dec_valid), 48'd0);
    endtask

    task automatic partial(input int n, input logic use_first);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) chk(dec_valid === 1'b0, "R8 no decision", 48'(dec_valid), 48'd0);
            in_valid = 1'b1;
            in_first = use_first && (i == 0);
            in_last  = 1'b0;
            in_data  = 8'hFF;
        end
        @(negedge clk);
        chk(dec_valid === 1'b0, "R8 no decision", 48'(dec_valid), 48'd0);
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] da;
        logic [47:0] sta;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(dec_valid === 1'b0, "R9 reset", 48'(dec_valid), 48'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(dec_valid === 1'b0, "R9 after reset", 48'(dec_valid), 48'd0);

        // R3: broadcast in all reject/promiscuous combinations
        for (int m = 0; m < 4; m++) begin
            bc_rej = m[0]; prom = m[1];
            send(48'hFFFF_FFFF_FFFF, 6, "R3 broadcast");
        end
        hall = 1'b1; bc_rej = 1'b1; prom = 1'b0;
        send(48'hFFFF_FFFF_FFFF, 6, "R3 broadcast over hash");
        hall = 1'b0; bc_rej = 1'b0;

        // R4/R5: multicast hash sweep under two table patterns
        h0 = 32'hA5A5_0F0F; h1 = 32'h3C3C_F00F;
        for (int k = 0; k < 150; k++) begin
            da = next_addr();
            da[40] = 1'b1;
            prom = k[0];
            send(da, 6, "R4 R5 multicast hash");
        end
        h0 = 32'h0000_0001; h1 = 32'h8000_0000;
        for (int k = 0; k < 64; k++) begin
            da = next_addr();
            da[40] = 1'b1;
            send(da, 6, "R5 hash table edges");
        end
        h0 = 32'hFFFF_FFFF; h1 = 32'hFFFF_FFFF; prom = 1'b0;
        send(48'h0100_5E00_0001, 6, "R5 all ones table");

        // R4: forced hash for unicast, including the station address itself
        h0 = 32'h5A5A_5A5A; h1 = 32'hC0C0_0303; hall = 1'b1;
        send({sta_hi, sta_lo}, 6, "R4 forced hash station");
        for (int k = 0; k < 40; k++) begin
            da = next_addr();
            da[40] = 1'b0;
            send(da, 6, "R4 forced hash unicast");
        end
        hall = 1'b0;

        // R6: exact match and single-byte mismatches at each position
        sta = {sta_hi, sta_lo};
        send(sta, 6, "R6 exact hit");
        for (int p = 0; p < 6; p++) begin
            send(sta ^ (48'h02 << (8 * (5 - p))), 6, "R6 byte mismatch");
        end
        prom = 1'b1;
        send(sta ^ 48'h10, 6, "R6 R7 promiscuous miss");
        prom = 1'b0;

        // R2: short frames of each length, both promiscuous settings
        for (int n = 1; n < 6; n++) begin
            prom = 1'b0;
            send(sta, n, "R2 short frame");
            prom = 1'b1;
            send(48'hFFFF_FFFF_FFFF, n, "R2 short frame");
        end
        prom = 1'b0;

        // R1: long frames, trailing bytes ignored
        send(sta, 12, "R1 long frame");
        send(48'h0100_5E7F_0102, 9, "R1 long multicast");

        // R8: restart mid-frame, then stray bytes with no frame open
        partial(3, 1'b1);
        send(sta, 6, "R8 restart");
        partial(4, 1'b0);
        partial(8, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule